// File: doc/BRIEF.md
# PCM Sample Unpacker with Volume

This block sits between a byte-wide playback FIFO and a stereo audio path. On every pulse of a sample-rate strobe it looks at the oldest bytes in the FIFO and turns them into one signed 16-bit left sample and one signed 16-bit right sample. A 2-bit format code selects how the bytes are packed. The same strobe tells the FIFO how many bytes to discard. Each channel then passes through a channel gain and a master gain, both unsigned Q15 values, and the result is saturated to the 16-bit range.

The FIFO shows its four oldest bytes on `fifo_head`, with the oldest byte in bits [7:0], and its occupancy on `fifo_level`. The pop request (`pop_valid` with `pop_count`) has no ready signal. The block only asks for bytes that `fifo_level` already reports as present, so the FIFO must accept every request in the cycle it is raised. The output sample also has no ready signal, so there is no back-pressure. `out_valid` pulses for one cycle after each strobe, and `out_left`/`out_right` keep their value until the next strobe. A consumer paced by the same strobe reads them whenever it needs them.

Top module: `pcm_unpack_vol`

## Requirements
- R1: The format code selects a frame size. 2'b00 is mono 8-bit (1 byte), 2'b01 is stereo 8-bit (2 bytes), 2'b10 is mono 16-bit (2 bytes) and 2'b11 is stereo 16-bit (4 bytes). When a strobe arrives and `fifo_level` is at least the frame size, `pop_valid` is 1 in that same cycle and `pop_count` equals the frame size.
- R2: An 8-bit byte becomes a 16-bit sample by inverting its bit 7 and placing the result in the upper byte, with the lower byte zero. For example, 0x00 becomes 0x8000 and 0xFF becomes 0x7F00. In stereo 8-bit, byte 0 is left and byte 1 is right.
- R3: In both mono formats, the single decoded sample drives both the left and right paths.
- R4: 16-bit samples are little-endian, with byte 0 as the low byte. In stereo 16-bit, bytes 0–1 hold the left sample and bytes 2–3 hold the right sample.
- R5: When a strobe arrives and `fifo_level` is below the frame size, `pop_valid` is 0, `pop_count` is 0, and both output samples become 0.
- R6: Each channel sample is multiplied by its channel gain and arithmetically shifted right by 15, rounding toward minus infinity. That result is multiplied by the channel's master gain and shifted right by 15 again. Gains are unsigned, and 0x8000 is unity.
- R7: The final value is clamped to the range -32768..32767.
- R8: The output registers load on the clock edge at which the strobe is high. `out_valid` is 1 for exactly the following cycle. Without a strobe, the outputs hold their value.
- R9: `pop_valid` is 0 and `pop_count` is 0 in every cycle without a strobe, whatever the FIFO holds.
- R10: After reset, `out_valid`, `out_left` and `out_right` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_strobe | input | 1 | One-cycle pulse at the sample rate |
| fmt | input | 2 | Packing format code |
| fifo_head | input | 32 | Four oldest FIFO bytes, oldest in [7:0] |
| fifo_level | input | 6 | FIFO occupancy in bytes (0..32) |
| gain_chan_l | input | 16 | Left channel gain, unsigned Q15 |
| gain_chan_r | input | 16 | Right channel gain, unsigned Q15 |
| gain_mst_l | input | 16 | Left master gain, unsigned Q15 |
| gain_mst_r | input | 16 | Right master gain, unsigned Q15 |
| pop_valid | output | 1 | Pop request to the FIFO |
| pop_count | output | 3 | Bytes to pop (0, 1, 2 or 4) |
| out_valid | output | 1 | New sample present this cycle |
| out_left | output | 16 | Left sample, signed |
| out_right | output | 16 | Right sample, signed |

## Verification
The assertions check the following on every cycle:
- Pops happen only on a strobe, and a pop never exceeds the reported occupancy.
- `pop_count` is always a legal frame size.
- `out_valid` trails the strobe by one cycle.
- The outputs hold between strobes.
- A strobe without a pop yields silence.
- In mono mode with matched gains, the left and right outputs agree.

Only the bench scenarios can show the following:
- The byte-to-sample conversions and little-endian ordering.
- The exact floor-rounded arithmetic of the two gain stages.
- Saturation at both ends of the range.

// File: rtl/pcm_unpack_pkg.sv
package pcm_unpack_pkg;

  localparam int SAMPLE_W = 16;
  localparam int BYTE_W   = 8;
  localparam int HEAD_BYTES = 4;

  typedef enum logic [1:0] {
    FMT_MONO8    = 2'b00,
    FMT_STEREO8  = 2'b01,
    FMT_MONO16   = 2'b10,
    FMT_STEREO16 = 2'b11
  } pcm_fmt_e;

  // Offset-binary byte to signed 16-bit sample.
  function automatic logic [SAMPLE_W-1:0] widen_u8(input logic [BYTE_W-1:0] b);
    return {~b[BYTE_W-1], b[BYTE_W-2:0], {BYTE_W{1'b0}}};
  endfunction

  function automatic logic [2:0] frame_bytes(input pcm_fmt_e f);
    case (f)
      FMT_MONO8:    return 3'd1;
      FMT_STEREO8:  return 3'd2;
      FMT_MONO16:   return 3'd2;
      default:      return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/pcm_frame_unpack.sv
module pcm_frame_unpack
  import pcm_unpack_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  pcm_fmt_e                           fmt_i,
  input  logic [HEAD_BYTES*BYTE_W-1:0]       head_i,
  input  logic [LVL_W-1:0]                   level_i,
  output logic                               enough_o,
  output logic [2:0]                         nbytes_o,
  output logic [SAMPLE_W-1:0]                raw_l_o,
  output logic [SAMPLE_W-1:0]                raw_r_o
);

  logic [BYTE_W-1:0] byte_q [HEAD_BYTES];

  for (genvar i = 0; i < HEAD_BYTES; i++) begin : g_split
    assign byte_q[i] = head_i[i*BYTE_W +: BYTE_W];
  end

  assign nbytes_o = frame_bytes(fmt_i);
  assign enough_o = (level_i >= LVL_W'(nbytes_o));

  always_comb begin
    raw_l_o = '0;
    raw_r_o = '0;
    case (fmt_i)
      FMT_MONO8: begin
        raw_l_o = widen_u8(byte_q[0]);
        raw_r_o = widen_u8(byte_q[0]);
      end
      FMT_STEREO8: begin
        raw_l_o = widen_u8(byte_q[0]);
        raw_r_o = widen_u8(byte_q[1]);
      end
      FMT_MONO16: begin
        raw_l_o = {byte_q[1], byte_q[0]};
        raw_r_o = {byte_q[1], byte_q[0]};
      end
      default: begin
        raw_l_o = {byte_q[1], byte_q[0]};
        raw_r_o = {byte_q[3], byte_q[2]};
      end
    endcase
  end

endmodule

// File: rtl/pcm_q15_gain.sv
module pcm_q15_gain #(
  parameter int IN_W   = 16,
  parameter int GAIN_W = 16,
  parameter int FRAC   = 15,
  parameter int OUT_W  = IN_W + GAIN_W - FRAC + 1
) (
  input  logic [IN_W-1:0]   din_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [OUT_W-1:0]  dout_o
);

  localparam int PW = IN_W + GAIN_W + 1;

  logic [PW-1:0]        din_x;
  logic [PW-1:0]        gain_x;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shifted;

  assign din_x   = {{(PW-IN_W){din_i[IN_W-1]}}, din_i};
  assign gain_x  = {{(PW-GAIN_W){1'b0}}, gain_i};
  assign prod    = din_x * gain_x;
  assign shifted = prod >>> FRAC;
  assign dout_o  = shifted[OUT_W-1:0];

endmodule

// File: rtl/pcm_sat.sv
module pcm_sat #(
  parameter int IN_W  = 20,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  din_i,
  output logic [OUT_W-1:0] dout_o
);

  logic [IN_W-OUT_W:0] top_bits;
  assign top_bits = din_i[IN_W-1:OUT_W-1];

  always_comb begin
    if ((&top_bits) || !(|top_bits))
      dout_o = din_i[OUT_W-1:0];
    else if (din_i[IN_W-1])
      dout_o = {1'b1, {(OUT_W-1){1'b0}}};
    else
      dout_o = {1'b0, {(OUT_W-1){1'b1}}};
  end

endmodule

// File: rtl/pcm_unpack_vol.sv
module pcm_unpack_vol
  import pcm_unpack_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int GAIN_W     = 16,
  parameter int FRAC       = 15,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample_strobe,
  input  logic [1:0]            fmt,
  input  logic [31:0]           fifo_head,
  input  logic [LVL_W-1:0]      fifo_level,
  input  logic [GAIN_W-1:0]     gain_chan_l,
  input  logic [GAIN_W-1:0]     gain_chan_r,
  input  logic [GAIN_W-1:0]     gain_mst_l,
  input  logic [GAIN_W-1:0]     gain_mst_r,
  output logic                  pop_valid,
  output logic [2:0]            pop_count,
  output logic                  out_valid,
  output logic [SAMPLE_W-1:0]   out_left,
  output logic [SAMPLE_W-1:0]   out_right
);

  localparam int NCH  = 2;
  localparam int S1_W = SAMPLE_W + GAIN_W - FRAC + 1;
  localparam int S2_W = S1_W + GAIN_W - FRAC + 1;

  logic                 enough;
  logic [2:0]           nbytes;
  logic [SAMPLE_W-1:0]  raw    [NCH];
  logic [GAIN_W-1:0]    g_chan [NCH];
  logic [GAIN_W-1:0]    g_mst  [NCH];
  logic [SAMPLE_W-1:0]  scaled [NCH];
  logic [SAMPLE_W-1:0]  out_q  [NCH];
  logic                 valid_q;

  pcm_frame_unpack #(.LVL_W(LVL_W)) unpack_i (
    .fmt_i    (pcm_fmt_e'(fmt)),
    .head_i   (fifo_head),
    .level_i  (fifo_level),
    .enough_o (enough),
    .nbytes_o (nbytes),
    .raw_l_o  (raw[0]),
    .raw_r_o  (raw[1])
  );

  assign g_chan[0] = gain_chan_l;
  assign g_chan[1] = gain_chan_r;
  assign g_mst[0]  = gain_mst_l;
  assign g_mst[1]  = gain_mst_r;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan_path
    logic [S1_W-1:0] stage1;
    logic [S2_W-1:0] stage2;

    pcm_q15_gain #(.IN_W(SAMPLE_W), .GAIN_W(GAIN_W), .FRAC(FRAC), .OUT_W(S1_W)) chan_gain_i (
      .din_i  (raw[ch]),
      .gain_i (g_chan[ch]),
      .dout_o (stage1)
    );

    pcm_q15_gain #(.IN_W(S1_W), .GAIN_W(GAIN_W), .FRAC(FRAC), .OUT_W(S2_W)) mst_gain_i (
      .din_i  (stage1),
      .gain_i (g_mst[ch]),
      .dout_o (stage2)
    );

    pcm_sat #(.IN_W(S2_W), .OUT_W(SAMPLE_W)) sat_i (
      .din_i  (stage2),
      .dout_o (scaled[ch])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        out_q[ch] <= '0;
      else if (sample_strobe)
        out_q[ch] <= enough ? scaled[ch] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= sample_strobe;
  end

  assign pop_valid = sample_strobe && enough;
  assign pop_count = pop_valid ? nbytes : 3'd0;
  assign out_valid = valid_q;
  assign out_left  = out_q[0];
  assign out_right = out_q[1];

endmodule

// File: rtl/pcm_unpack_vol_chk.sv
module pcm_unpack_vol_chk #(
  parameter int LVL_W  = 6,
  parameter int GAIN_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_strobe,
  input logic [1:0]        fmt,
  input logic [LVL_W-1:0]  fifo_level,
  input logic [GAIN_W-1:0] gain_chan_l,
  input logic [GAIN_W-1:0] gain_chan_r,
  input logic [GAIN_W-1:0] gain_mst_l,
  input logic [GAIN_W-1:0] gain_mst_r,
  input logic              pop_valid,
  input logic [2:0]        pop_count,
  input logic              out_valid,
  input logic [15:0]       out_left,
  input logic [15:0]       out_right
);

  a_r9_pop_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_strobe |-> (!pop_valid && pop_count == 3'd0));

  a_r1_legal_size: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> ((pop_count == 3'd1 || pop_count == 3'd2 || pop_count == 3'd4)
                   && LVL_W'(pop_count) <= fifo_level));

  a_r8_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> out_valid);

  a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_strobe |=> !out_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_strobe |=> ($stable(out_left) && $stable(out_right)));

  a_r5_silence: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe && !pop_valid) |=> (out_left == 16'd0 && out_right == 16'd0));

  a_r3_mono_match: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe && !fmt[0] && gain_chan_l == gain_chan_r && gain_mst_l == gain_mst_r)
      |=> (out_left == out_right));

endmodule

bind pcm_unpack_vol pcm_unpack_vol_chk #(.LVL_W(LVL_W), .GAIN_W(GAIN_W)) chk_i (.*);

// File: tb/pcm_unpack_vol_tb.sv
module pcm_unpack_vol_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_strobe = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic [31:0] fifo_head = '0;
  logic [5:0]  fifo_level = '0;
  logic [15:0] gain_chan_l = 16'h8000;
  logic [15:0] gain_chan_r = 16'h8000;
  logic [15:0] gain_mst_l  = 16'h8000;
  logic [15:0] gain_mst_r  = 16'h8000;
  logic        pop_valid;
  logic [2:0]  pop_count;
  logic        out_valid;
  logic [15:0] out_left;
  logic [15:0] out_right;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pcm_unpack_vol dut_i (
    .clk(clk), .rst_n(rst_n), .sample_strobe(sample_strobe), .fmt(fmt),
    .fifo_head(fifo_head), .fifo_level(fifo_level),
    .gain_chan_l(gain_chan_l), .gain_chan_r(gain_chan_r),
    .gain_mst_l(gain_mst_l), .gain_mst_r(gain_mst_r),
    .pop_valid(pop_valid), .pop_count(pop_count), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint q15(input longint v, input longint g);
    return (v * g) >>> 15;
  endfunction

  function automatic longint clamp16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint s16(input logic [15:0] x);
    logic signed [15:0] t;
    t = x;
    return longint'(t);
  endfunction

  // Drives one strobe and checks pop, outputs and hold behaviour.
  task automatic run_frame(input string req, input logic [1:0] f, input logic [31:0] head,
                           input logic [5:0] lvl, input logic [15:0] gcl, input logic [15:0] gcr,
                           input logic [15:0] gml, input logic [15:0] gmr);
    logic [7:0] b0, b1, b2, b3;
    longint rl, rr, el, er;
    int need;
    b0 = head[7:0]; b1 = head[15:8]; b2 = head[23:16]; b3 = head[31:24];
    case (f)
      2'b00: begin need = 1; rl = s16({~b0[7], b0[6:0], 8'h00}); rr = rl; end
      2'b01: begin need = 2; rl = s16({~b0[7], b0[6:0], 8'h00}); rr = s16({~b1[7], b1[6:0], 8'h00}); end
      2'b10: begin need = 2; rl = s16({b1, b0}); rr = rl; end
      default: begin need = 4; rl = s16({b1, b0}); rr = s16({b3, b2}); end
    endcase
    if (lvl < need) begin
      el = 0; er = 0; need = 0;
    end else begin
      el = clamp16(q15(q15(rl, gcl), gml));
      er = clamp16(q15(q15(rr, gcr), gmr));
    end
    @(negedge clk);
    fmt = f; fifo_head = head; fifo_level = lvl;
    gain_chan_l = gcl; gain_chan_r = gcr; gain_mst_l = gml; gain_mst_r = gmr;
    sample_strobe = 1'b1;
    #1;
    check(req, "pop_valid", pop_valid, need != 0);
    check(req, "pop_count", pop_count, need);
    @(negedge clk);
    sample_strobe = 1'b0;
    check("R8", "out_valid after strobe", out_valid, 1);
    check(req, "left", s16(out_left), el);
    check(req, "right", s16(out_right), er);
    fifo_head = ~head; fifo_level = 6'd32;
    #1;
    check("R9", "pop_valid idle", pop_valid, 0);
    check("R9", "pop_count idle", pop_count, 0);
    @(negedge clk);
    check("R8", "out_valid idle", out_valid, 0);
    check("R8", "left held", s16(out_left), el);
    check("R8", "right held", s16(out_right), er);
  endtask

  task automatic t_reset();
    #1;
    check("R10", "out_valid reset", out_valid, 0);
    check("R10", "left reset", out_left, 0);
    check("R10", "right reset", out_right, 0);
  endtask

  task automatic t_mono8();  // R2 R3
    run_frame("R2", 2'b00, 32'h0000_0040, 6'd1, 16'h8000, 16'h8000, 16'h8000, 16'h8000);
    check("R3", "mono8 left value", s16(out_left), -16384);
    run_frame("R3", 2'b00, 32'h0000_0000, 6'd5, 16'h8000, 16'h8000, 16'h8000, 16'h8000);
    check("R2", "byte 0x00 maps to min", s16(out_right), -32768);
  endtask

  task automatic t_stereo8();
    run_frame("R2", 2'b01, 32'h0000_00FF, 6'd2, 16'h8000, 16'h8000, 16'h8000, 16'h8000);
    check("R2", "byte 0xFF maps to 0x7F00", out_left, 16'h7F00);
    check("R1", "stereo8 right from byte1", out_right, 16'h8000);
  endtask

  task automatic t_mono16();
    run_frame("R4", 2'b10, 32'hEEEE_1234, 6'd2, 16'h8000, 16'h8000, 16'h8000, 16'h8000);
    check("R4", "little-endian mono", out_left, 16'h1234);
    check("R3", "mono16 duplicated", out_right, 16'h1234);
  endtask

  task automatic t_stereo16();
    run_frame("R4", 2'b11, 32'hBBAA_2211, 6'd4, 16'h8000, 16'h8000, 16'h8000, 16'h8000);
    check("R4", "left first", out_left, 16'h2211);
    check("R4", "right second", out_right, 16'hBBAA);
    run_frame("R1", 2'b11, 32'h8001_7FFE, 6'd32, 16'h8000, 16'h8000, 16'h8000, 16'h8000);
  endtask

  task automatic t_underflow();
    run_frame("R5", 2'b11, 32'h7777_7777, 6'd3, 16'h8000, 16'h8000, 16'h8000, 16'h8000);
    run_frame("R5", 2'b00, 32'h0000_0011, 6'd0, 16'h8000, 16'h8000, 16'h8000, 16'h8000);
    run_frame("R5", 2'b01, 32'h0000_1111, 6'd1, 16'h8000, 16'h8000, 16'h8000, 16'h8000);
  endtask

  task automatic t_gain();
    run_frame("R6", 2'b11, 32'hFFFF_1234, 6'd4, 16'h4000, 16'h4000, 16'h8000, 16'h4000);
    check("R6", "half gain left", s16(out_left), 2330);
    check("R6", "floor rounding right", s16(out_right), -1);
    run_frame("R6", 2'b11, 32'hC000_4000, 6'd8, 16'h0000, 16'h6000, 16'h8000, 16'h2000);
    run_frame("R6", 2'b10, 32'h0000_F000, 6'd2, 16'h8000, 16'h8000, 16'hA000, 16'h0000);
  endtask

  task automatic t_clamp();
    run_frame("R7", 2'b11, 32'h8000_7FFF, 6'd4, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    check("R7", "positive clamp", s16(out_left), 32767);
    check("R7", "negative clamp", s16(out_right), -32768);
    run_frame("R7", 2'b01, 32'h0000_10F0, 6'd2, 16'hC000, 16'hC000, 16'hC000, 16'hC000);
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mono8();
    t_stereo8();
    t_mono16();
    t_stereo16();
    t_underflow();
    t_gain();
    t_clamp();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule